// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block sits between a pulse-shaping filter and the interpolation stages of a transmit channel and sets the amplitude envelope of the complex sample stream. Each I/Q sample is multiplied by an unsigned gain coefficient taken from a small ramp memory. In steady state the gain is the last coefficient of the programmed ramp. A trigger pulse starts one power-ramp sequence. The gain first falls through the coefficients, last to first. The output is then held silent for a programmable number of samples. Finally the gain climbs back through the coefficients, first to last.

While the sequence is silent, the block pulses a strobe so that neighbouring shadowed configuration can change between timeslots. At the same moment it takes the new ramp length and interpolation mode for itself. The interpolation mode holds each coefficient for two samples, which doubles the time the ramp takes. When the ramp function is disabled, samples pass through unchanged with the same one-cycle latency.

Top module: `tx_ramp_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_i`, `out_q` and `shadow_upd` are 0 after that edge, and the active configuration becomes length 1 with interpolation off.
- R2: With `ramp_en` low, a sample accepted with `in_valid` at an edge appears unchanged on `out_i`/`out_q` after that edge. `out_valid` always equals `in_valid` of the previous edge, and the output data hold when no sample is accepted.
- R3: With `ramp_en` high and no sequence running, each sample is scaled by the coefficient at memory address L-1, where L is the active effective length. Coefficients are 14-bit unsigned values with weight 2^-14 (range [0,1)).
- R4: Scaling computes floor((x*c + 8192) / 16384) for a signed 16-bit sample x and coefficient c. For example, x=3 and c=8192 give 2, x=-3 and c=8192 give -1, x=-32768 and c=16383 give -32766, and x=32767 and c=16383 give 32765.
- R5: A `trigger` high at an edge while `ramp_en` is high and the block is idle starts the ramp-down. The sample accepted at that same edge still uses the idle gain. The following accepted samples use addresses L-1, L-2, and so on down to 0, one address per sample.
- R6: After the ramp-down, the next min(`rest_len`,32) accepted samples give `out_valid`=1 with both outputs 0, and their input data are discarded. A value of 0 skips the rest period.
- R7: After the rest period, accepted samples use addresses 0, 1, and so on up to L-1, and the block then returns to idle.
- R8: With the active interpolation flag set, each address of the ramp-down and of the ramp-up applies to two consecutive accepted samples.
- R9: The effective length is `ramp_len` limited to 64 when `interp_en` is low and to 128 when it is high. A `ramp_len` of 0 counts as 1.
- R10: `shadow_upd` is high for exactly one cycle, after the edge that accepts the final ramp-down sample. At that edge the active length and interpolation flag are taken from `ramp_len`/`interp_en`, and the ramp-up uses them. These inputs are also taken at every edge with `ramp_en` low. At other times changes to them have no effect.
- R11: `trigger` has no effect while a sequence is running or while `ramp_en` is low.
- R12: Lowering `ramp_en` switches to pass-through at the same edge and abandons any running sequence. When `ramp_en` is raised again, the block is idle.
- R13: `mem_we` high at an edge writes `mem_wdata` to address `mem_addr`. A sample accepted at that same edge still sees the old word, and samples at later edges see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ramp_en | input | 1 | Enables the ramp stage; low selects pass-through |
| interp_en | input | 1 | Holds each coefficient for two samples (taken at update points) |
| ramp_len | input | 8 | Requested number of ramp coefficients |
| rest_len | input | 6 | Silent samples between ramp-down and ramp-up (limited to 32) |
| trigger | input | 1 | Starts a ramp sequence when idle |
| mem_we | input | 1 | Ramp memory write enable |
| mem_addr | input | 7 | Ramp memory write address |
| mem_wdata | input | 14 | Ramp memory write word, unsigned gain |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase sample, signed |
| out_q | output | 16 | Scaled quadrature sample, signed |
| shadow_upd | output | 1 | One-cycle strobe marking the update point |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 14-bit coefficients, a 128-word ramp memory and a rest period of up to 32 samples. With these values, a full 128-coefficient interpolated sequence, the 64-coefficient limit without interpolation and a maximum-length rest all fit in one run. A `rest_len` of 40, which the 6-bit field can carry, is used to show the limit at 32. The sample stream is gated at random so that ramp steps, rest counting and trigger handling are seen with gaps between accepted samples.

// File: rtl/tx_ramp_pkg.sv
// Shared types for the transmit power ramp sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tx_ramp_pkg;

    // Sequence phase of the ramp controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DOWN = 2'd1,
        PH_REST = 2'd2,
        PH_UP   = 2'd3
    } ramp_phase_e;

    // What the scaler does with the current sample.
    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_SCALE = 2'd1,
        SEL_ZERO  = 2'd2
    } out_sel_e;

endpackage

// File: rtl/ramp_coef_mem.sv
// Ramp coefficient store: one write port, one combinational read port.
// Assumes writes come from configuration logic; a read at the same edge
// as a write returns the previous word. Contents are not reset.
module ramp_coef_mem #(
    parameter int COEF_W = 14,
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [COEF_W-1:0] rd_data
);

    logic [COEF_W-1:0] store [DEPTH];

    // Write one coefficient word per enabled edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the addressed coefficient.
    always_comb begin
        rd_data = store[rd_addr];
    end

endmodule

// File: rtl/ramp_seq_ctrl.sv
// Ramp sequence controller: walks the coefficient address down, through a
// silent rest and back up, one step per accepted sample (two when the
// active interpolation flag is set). Holds the active length/interp
// configuration, reloaded in bypass and at the end of the ramp-down.
// Assumes synchronous active-low reset and a single clock.
module ramp_seq_ctrl
    import tx_ramp_pkg::*;
#(
    parameter int MAX_LEN  = 128,
    parameter int MAX_REST = 32,
    parameter int ADDR_W   = $clog2(MAX_LEN),
    parameter int LEN_W    = $clog2(MAX_LEN + 1),
    parameter int REST_W   = $clog2(MAX_REST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ramp_en,
    input  logic              interp_en,
    input  logic [LEN_W-1:0]  ramp_len,
    input  logic [REST_W-1:0] rest_len,
    input  logic              trigger,
    input  logic              in_valid,
    output logic [ADDR_W-1:0] coef_addr,
    output out_sel_e          out_sel,
    output logic              shadow_upd
);

    localparam logic [LEN_W-1:0]  LEN_CAP_INTERP = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0]  LEN_CAP_PLAIN  = LEN_W'(MAX_LEN / 2);
    localparam logic [REST_W-1:0] REST_CAP       = REST_W'(MAX_REST);

    ramp_phase_e       phase;
    logic [ADDR_W-1:0] idx;
    logic              rep;
    logic [REST_W-1:0] rest_cnt;
    logic [LEN_W-1:0]  act_len;
    logic              act_interp;
    logic              shadow_q;

    logic [LEN_W-1:0]  len_cap;
    logic [LEN_W-1:0]  new_len;
    logic [REST_W-1:0] rest_eff;
    logic [ADDR_W-1:0] last_idx;
    logic              step_done;
    logic              down_end;

    // Limit the requested length and rest count to their legal ranges.
    always_comb begin
        len_cap  = interp_en ? LEN_CAP_INTERP : LEN_CAP_PLAIN;
        if (ramp_len == '0) begin
            new_len = LEN_W'(1);
        end else if (ramp_len > len_cap) begin
            new_len = len_cap;
        end else begin
            new_len = ramp_len;
        end
        rest_eff  = (rest_len > REST_CAP) ? REST_CAP : rest_len;
        last_idx  = ADDR_W'(act_len - LEN_W'(1));
        step_done = !act_interp || rep;
        down_end  = ramp_en && (phase == PH_DOWN) && in_valid && step_done
                    && (idx == '0);
    end

    // Active configuration: follows inputs in bypass, reloads at down end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len    <= LEN_W'(1);
            act_interp <= 1'b0;
        end else if (!ramp_en || down_end) begin
            act_len    <= new_len;
            act_interp <= interp_en;
        end
    end

    // One-cycle update strobe after the last ramp-down sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
        end else begin
            shadow_q <= down_end;
        end
    end

    // Phase, address, repeat and rest counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            idx      <= '0;
            rep      <= 1'b0;
            rest_cnt <= '0;
        end else if (!ramp_en) begin
            phase <= PH_IDLE;
            rep   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (trigger) begin
                        phase <= PH_DOWN;
                        idx   <= last_idx;
                        rep   <= 1'b0;
                    end
                end
                PH_DOWN: begin
                    if (in_valid) begin
                        if (!step_done) begin
                            rep <= 1'b1;
                        end else begin
                            rep <= 1'b0;
                            if (idx == '0) begin
                                if (rest_eff == '0) begin
                                    phase <= PH_UP;
                                    idx   <= '0;
                                end else begin
                                    phase    <= PH_REST;
                                    rest_cnt <= rest_eff;
                                end
                            end else begin
                                idx <= idx - ADDR_W'(1);
                            end
                        end
                    end
                end
                PH_REST: begin
                    if (in_valid) begin
                        if (rest_cnt == REST_W'(1)) begin
                            phase <= PH_UP;
                            idx   <= '0;
                            rep   <= 1'b0;
                        end else begin
                            rest_cnt <= rest_cnt - REST_W'(1);
                        end
                    end
                end
                default: begin
                    if (in_valid) begin
                        if (!step_done) begin
                            rep <= 1'b1;
                        end else begin
                            rep <= 1'b0;
                            if (idx == last_idx) begin
                                phase <= PH_IDLE;
                            end else begin
                                idx <= idx + ADDR_W'(1);
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Address and output selection for the current sample.
    always_comb begin
        coef_addr  = (phase == PH_IDLE) ? last_idx : idx;
        shadow_upd = shadow_q;
        if (!ramp_en) begin
            out_sel = SEL_PASS;
        end else if (phase == PH_REST) begin
            out_sel = SEL_ZERO;
        end else begin
            out_sel = SEL_SCALE;
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DOWN || phase == PH_UP) |-> (idx <= last_idx)); // R9
    AST_REST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REST) |-> (rest_cnt != '0 && rest_cnt <= REST_CAP)); // R6
    AST_SHADOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_upd |=> !shadow_upd); // R10
    AST_SHADOW_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_upd |-> (phase == PH_REST || phase == PH_UP)); // R10
    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && phase == PH_IDLE && trigger) |=> (phase == PH_DOWN)); // R5
    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && phase != PH_IDLE && !in_valid) |=> (phase == $past(phase))); // R11
    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_en |=> (phase == PH_IDLE)); // R12

endmodule

// File: rtl/ramp_scaler.sv
// Complex sample scaler: multiplies I and Q by an unsigned Q0.COEF_W gain
// with round-half-up, or passes the sample through, or forces zero.
// Registers the result; output data hold when no sample is accepted.
// Assumes the gain is below 1, so the rounded result fits DATA_W.
module ramp_scaler
    import tx_ramp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic        [COEF_W-1:0] coef,
    input  out_sel_e                 sel,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);

    localparam int LANES  = 2;
    localparam int PROD_W = DATA_W + COEF_W + 1;
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (COEF_W - 1);

    logic signed [DATA_W-1:0] lane_in  [LANES];
    logic signed [DATA_W-1:0] lane_res [LANES];

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    // Multiply, round half up and select per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PROD_W-1:0] xa;
        logic signed [PROD_W-1:0] ca;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] rnd;
        always_comb begin
            xa   = PROD_W'(lane_in[g]);
            ca   = PROD_W'({1'b0, coef});
            prod = xa * ca;
            rnd  = (prod + HALF_LSB) >>> COEF_W;
            case (sel)
                SEL_PASS:  lane_res[g] = lane_in[g];
                SEL_ZERO:  lane_res[g] = '0;
                default:   lane_res[g] = DATA_W'(rnd);
            endcase
        end
    end

    // Output register: strobe every cycle, data only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= lane_res[0];
                out_q <= lane_res[1];
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q))); // R2
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == SEL_PASS) |=>
        (out_i == $past(in_i) && out_q == $past(in_q))); // R2
    AST_REST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == SEL_ZERO) |=> (out_i == '0 && out_q == '0)); // R6

endmodule

// File: rtl/tx_ramp_seq.sv
// Transmit power ramp sequencer top: coefficient store, sequence
// controller and I/Q scaler. One cycle from accepted sample to output.
// Assumes one clock and a synchronous active-low reset.
module tx_ramp_seq
    import tx_ramp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 14,
    parameter int MAX_LEN  = 128,
    parameter int MAX_REST = 32,
    localparam int ADDR_W  = $clog2(MAX_LEN),
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int REST_W  = $clog2(MAX_REST + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ramp_en,
    input  logic                     interp_en,
    input  logic [LEN_W-1:0]         ramp_len,
    input  logic [REST_W-1:0]        rest_len,
    input  logic                     trigger,
    input  logic                     mem_we,
    input  logic [ADDR_W-1:0]        mem_addr,
    input  logic [COEF_W-1:0]        mem_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic                     shadow_upd
);

    logic [ADDR_W-1:0] coef_addr;
    logic [COEF_W-1:0] coef_word;
    out_sel_e          out_sel;

    ramp_coef_mem #(
        .COEF_W (COEF_W),
        .DEPTH  (MAX_LEN),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata),
        .rd_addr (coef_addr),
        .rd_data (coef_word)
    );

    ramp_seq_ctrl #(
        .MAX_LEN  (MAX_LEN),
        .MAX_REST (MAX_REST),
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .REST_W   (REST_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ramp_en    (ramp_en),
        .interp_en  (interp_en),
        .ramp_len   (ramp_len),
        .rest_len   (rest_len),
        .trigger    (trigger),
        .in_valid   (in_valid),
        .coef_addr  (coef_addr),
        .out_sel    (out_sel),
        .shadow_upd (shadow_upd)
    );

    ramp_scaler #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .coef      (coef_word),
        .sel       (out_sel),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !shadow_upd)); // R1

endmodule

// File: tb/tx_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module tx_ramp_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ramp_en = 1'b0, interp_en = 1'b0, trigger = 1'b0;
    logic [7:0]  ramp_len = 8'd1;
    logic [5:0]  rest_len = 6'd0;
    logic        mem_we = 1'b0;
    logic [6:0]  mem_addr = '0;
    logic [13:0] mem_wdata = '0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic        out_valid, shadow_upd;
    logic signed [15:0] out_i, out_q;

    always #2.5 clk = ~clk;

    tx_ramp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ramp_en(ramp_en), .interp_en(interp_en),
        .ramp_len(ramp_len), .rest_len(rest_len), .trigger(trigger),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .shadow_upd(shadow_upd)
    );

    int n_cmp = 0, n_bad = 0;
    string scen = "R1";

    // Reference model state (0 idle, 1 down, 2 rest, 3 up).
    int mem_m [128];
    int m_ph = 0, m_idx = 0, m_rep = 0, m_cnt = 0, m_len = 1, m_int = 0;
    int e_v = 0, e_i = 0, e_q = 0, e_sh = 0;
    bit m_ok = 0;
    string e_tag = "R1";

    function automatic int eff_len(int len, int intp);
        int cap = intp ? 128 : 64;
        if (len == 0) return 1;
        if (len > cap) return cap;
        return len;
    endfunction

    function automatic int scale(int x, int c);
        longint t = longint'(x) * longint'(c) + 64'sd8192;
        return int'(t >>> 14);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_rep = 0; m_cnt = 0; m_len = 1; m_int = 0;
            e_v = 0; e_i = 0; e_q = 0; e_sh = 0; e_tag = "R1"; m_ok = 1;
        end else begin
            int c;
            int r;
            e_sh = 0;
            e_v  = in_valid;
            if (in_valid) begin
                if (!ramp_en) begin
                    e_i = in_i; e_q = in_q; e_tag = "R2";
                end else if (m_ph == 2) begin
                    e_i = 0; e_q = 0; e_tag = "R6";
                end else begin
                    c = (m_ph == 0) ? mem_m[m_len-1] : mem_m[m_idx];
                    e_i = scale(in_i, c); e_q = scale(in_q, c);
                    e_tag = (m_ph == 0) ? "R3" : (m_int ? "R8" : (m_ph == 1 ? "R5" : "R7"));
                end
            end
            if (mem_we) mem_m[mem_addr] = mem_wdata;
            if (!ramp_en) begin
                m_ph = 0; m_rep = 0; m_len = eff_len(ramp_len, interp_en); m_int = interp_en;
            end else if (m_ph == 0) begin
                if (trigger) begin m_ph = 1; m_idx = m_len - 1; m_rep = 0; end
            end else if (in_valid) begin
                if (m_ph == 2) begin
                    if (m_cnt == 1) begin m_ph = 3; m_idx = 0; m_rep = 0; end
                    else m_cnt--;
                end else if (m_int && m_rep == 0) begin
                    m_rep = 1;
                end else begin
                    m_rep = 0;
                    if (m_ph == 1) begin
                        if (m_idx == 0) begin
                            e_sh = 1;
                            m_len = eff_len(ramp_len, interp_en); m_int = interp_en;
                            r = (rest_len > 32) ? 32 : rest_len;
                            if (r == 0) begin m_ph = 3; m_idx = 0; end
                            else begin m_ph = 2; m_cnt = r; end
                        end else m_idx--;
                    end else begin
                        if (m_idx == m_len - 1) m_ph = 0;
                        else m_idx++;
                    end
                end
            end
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (m_ok) begin
            n_cmp++;
            if (out_valid !== 1'(e_v) || int'(out_i) != e_i || int'(out_q) != e_q
                || shadow_upd !== 1'(e_sh)) begin
                n_bad++;
                $display("FAIL [%s %s] t=%0t act v=%0d i=%0d q=%0d sh=%0d exp v=%0d i=%0d q=%0d sh=%0d",
                         scen, e_sh ? "R10" : e_tag, $time, out_valid, out_i, out_q,
                         shadow_upd, e_v, e_i, e_q, e_sh);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n, int pct);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            trigger  = 1'b0;
            mem_we   = 1'b0;
            in_valid = ($urandom % 100) < pct;
            in_i     = 16'($urandom);
            in_q     = 16'($urandom);
        end
    endtask

    task automatic trig();
        @(negedge clk);
        mem_we   = 1'b0;
        trigger  = 1'b1;
        in_valid = $urandom % 2;
        in_i     = 16'($urandom);
        in_q     = 16'($urandom);
    endtask

    task automatic wr(int a, int d, bit v);
        @(negedge clk);
        trigger   = 1'b0;
        mem_we    = 1'b1;
        mem_addr  = 7'(a);
        mem_wdata = 14'(d);
        in_valid  = v;
        in_i      = 16'($urandom);
        in_q      = 16'($urandom);
    endtask

    task automatic one(int xi, int xq);
        @(negedge clk);
        trigger = 1'b0; mem_we = 1'b0;
        in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL [watchdog] actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        scen = "R1";
        repeat (5) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_i", out_i, 0);
        chk("R1 shadow_upd", shadow_upd, 0);
        rst_n = 1'b1;
        // R13: load coefficients
        scen = "R13";
        for (int k = 0; k < 128; k++) wr(k, (k * 131 + 57) % 16384, 1'b0);
        // R2 bypass; R11 trigger ignored while disabled
        scen = "R2";
        cyc(20, 70);
        scen = "R11";
        trig();
        cyc(6, 80);
        // R3 idle gain, R5/R6/R7 plain sequence, R11 retrigger ignored
        scen = "R5";
        ramp_len = 8; interp_en = 0; rest_len = 3;
        cyc(2, 50);
        ramp_en = 1;
        cyc(10, 80);
        trig();
        cyc(8, 80);
        scen = "R11";
        trig();
        cyc(40, 80);
        // R4: rounding corner values at address 7
        scen = "R4";
        wr(7, 8192, 1'b0);
        one(3, -3);
        chk("R4 x=3 c=8192", out_i, 2);
        chk("R4 x=-3 c=8192", out_q, -1);
        wr(7, 16383, 1'b0);
        one(-32768, 32767);
        chk("R4 x=-32768 c=16383", out_i, -32766);
        chk("R4 x=32767 c=16383", out_q, 32765);
        // R8 interpolation with zero rest
        scen = "R8";
        ramp_en = 0; interp_en = 1; ramp_len = 5; rest_len = 0;
        cyc(2, 50);
        ramp_en = 1;
        trig();
        cyc(40, 100);
        // R10: config changes apply only at the update point; rest clamp R6
        scen = "R10";
        ramp_len = 20; interp_en = 0; rest_len = 40;
        cyc(6, 70);
        trig();
        cyc(3, 90);
        ramp_len = 12;
        cyc(150, 90);
        // R9: length limits
        scen = "R9";
        ramp_en = 0; ramp_len = 100; interp_en = 0;
        cyc(2, 50);
        ramp_en = 1;
        cyc(4, 100);
        ramp_en = 0; ramp_len = 0;
        cyc(2, 50);
        ramp_en = 1;
        cyc(4, 100);
        trig();
        cyc(10, 100);
        ramp_en = 0; ramp_len = 128; interp_en = 1; rest_len = 32;
        cyc(2, 50);
        ramp_en = 1;
        trig();
        cyc(620, 100);
        // R12: abort mid ramp-down
        scen = "R12";
        ramp_len = 10; rest_len = 2;
        trig();
        cyc(5, 100);
        ramp_en = 0;
        cyc(5, 100);
        ramp_en = 1;
        cyc(5, 100);
        // R13: write during a running sequence
        scen = "R13";
        trig();
        cyc(4, 100);
        wr(3, 5000, 1'b1);
        wr(0, 12000, 1'b1);
        cyc(80, 100);
        summary();
        $finish;
    end

endmodule